// File: doc/BRIEF.md
# Configurable Output Macrocell for Sum-of-Products Logic

This block is one output cell of a registered programmable-logic array. It receives a small group of product terms that some upstream AND plane produces. It merges them into one sum and can flip the sense of that sum. The sum goes either straight to the pin or through a storage flip-flop. The cell also decides when the pin is driven and which signal returns to the AND plane as feedback.

Every choice is made by static configuration inputs. These are the sum mode (plain OR or a split exclusive-OR), the flip-flop type (data or toggle), the active clock edge, the clock source (global clock or a product-term clock), the pin direction mode and the feedback source. Separate product terms drive the output enable, the local clock and an asynchronous clear. The pin is a three-signal model: drive value, drive enable and the sensed pad value. When the drive is disabled, the drive value is held at 0.

Top module: `pld_macrocell`

## Requirements
- R1: With storage bypassed (`cfg_reg_i`=0), split mode off and polarity 0, `pin_o` equals the OR of all `pt_sum_i` bits whenever the pin is driven.
- R2: When `cfg_pol_i`=1, the value sent to the pin is inverted, in both the bypass path and the registered path.
- R3: When `cfg_xor_i`=1, the sum is the OR of `pt_sum_i[3:0]` exclusive-ORed with the OR of `pt_sum_i[7:4]`.
- R4: In data mode (`cfg_tff_i`=0) the flip-flop loads the sum at the active edge. With `cfg_reg_i`=1 the pin shows the stored bit, subject to polarity.
- R5: In toggle mode (`cfg_tff_i`=1) the stored bit inverts at an active edge when the sum is 1 and holds when the sum is 0.
- R6: When `cfg_negedge_i`=1, the flip-flop updates on the falling edge of its selected clock and not on the rising edge.
- R7: When `cfg_lclk_i`=1, the flip-flop is clocked by `pt_clk_i` and edges of `clk_i` have no effect.
- R8: While `pt_clr_i`=1, or while `rst_ni`=0, the stored bit is 0 at once and clock edges are ignored.
- R9: `cfg_pin_mode_i` selects the drive enable: 0 follows `pt_oe_i`, 1 is always driven, and 2 or 3 is never driven (dedicated input).
- R10: When the pin is not driven, `pin_o` is 0.
- R11: When `cfg_fb_pin_i`=0, `fb_o` is the stored bit whatever the pin does, so the register can be buried. When `cfg_fb_pin_i`=1, `fb_o` is the driven value while the pin is enabled and `pin_i` while it is not.
- R12: In dedicated-input modes (2 or 3), `fb_o` equals `pin_i` regardless of `cfg_fb_pin_i`.
- R13: Two cells in toggle mode with register feedback can form a 2-bit binary counter. The low cell's sum is constant 1, and the high cell's sum is the low cell's feedback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Global clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the stored bit |
| pt_sum_i | input | N_PT | Product terms feeding the sum |
| pt_oe_i | input | 1 | Product term for the output enable in bidirectional mode |
| pt_clk_i | input | 1 | Product-term local clock |
| pt_clr_i | input | 1 | Product term for the asynchronous clear |
| cfg_pol_i | input | 1 | Output inversion |
| cfg_xor_i | input | 1 | Split exclusive-OR sum mode |
| cfg_reg_i | input | 1 | 1 routes the stored bit to the pin, 0 routes the sum |
| cfg_tff_i | input | 1 | 1 selects toggle mode, 0 selects data mode |
| cfg_negedge_i | input | 1 | 1 selects the falling clock edge |
| cfg_lclk_i | input | 1 | 1 selects the product-term clock |
| cfg_pin_mode_i | input | 2 | Pin direction mode |
| cfg_fb_pin_i | input | 1 | Feedback source: 1 selects the pin, 0 selects the register |
| pin_i | input | 1 | Sensed pad value |
| pin_o | output | 1 | Pad drive value |
| pin_oe_o | output | 1 | Pad drive enable |
| fb_o | output | 1 | Feedback to the AND plane |

## Verification
The hardest state to reach from the ports is a stored bit that differs from the pin value. This happens when the register is buried behind a disabled or input-only pin, where only the feedback output can reveal it. The bench loads a 1 through the data path while the pin is enabled. It then switches the cell to a non-driving mode without clearing it. Finally it drives the opposite level on `pin_i` and checks that register feedback still returns the stored 1, while pin feedback and the dedicated-input override return the pad level. The falling-edge and local-clock cases are reached by sampling between edges of the global clock and by pulsing `pt_clk_i` by hand. This shows which clock, and which edge, moved the bit.

// File: rtl/pmc_pkg.sv
`timescale 1ns/1ps
package pmc_pkg;
  typedef enum logic [1:0] {
    PIN_BIDIR  = 2'd0,
    PIN_OUT    = 2'd1,
    PIN_IN     = 2'd2,
    PIN_IN_ALT = 2'd3
  } pin_mode_e;
endpackage

// File: rtl/pmc_sum.sv
`timescale 1ns/1ps
module pmc_sum #(
  parameter int N_PT = 8
) (
  input  logic [N_PT-1:0] pt_i,
  input  logic            xor_en_i,
  output logic            sum_o
);
  localparam int HALF = N_PT / 2;

  generate
    if (N_PT >= 2) begin : g_split
      logic lo, hi;
      assign lo    = |pt_i[HALF-1:0];
      assign hi    = |pt_i[N_PT-1:HALF];
      assign sum_o = xor_en_i ? (lo ^ hi) : (lo | hi);
    end else begin : g_single
      logic unused_xor;
      assign unused_xor = xor_en_i;
      assign sum_o      = pt_i[0];
    end
  endgenerate
endmodule

// File: rtl/pmc_ff.sv
`timescale 1ns/1ps
module pmc_ff (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lclk_i,
  input  logic lclk_sel_i,
  input  logic negedge_i,
  input  logic tff_i,
  input  logic clr_i,
  input  logic d_i,
  output logic q_o
);
  logic clk_sel, clk_eff, clr_any, q_r;

  // edge choice folded into the clock path: one flop serves both edges
  assign clk_sel = lclk_sel_i ? lclk_i : clk_i;
  assign clk_eff = clk_sel ^ negedge_i;
  assign clr_any = clr_i | ~rst_ni;

  always_ff @(posedge clk_eff or posedge clr_any) begin
    if (clr_any)    q_r <= 1'b0;
    else if (tff_i) q_r <= q_r ^ d_i;
    else            q_r <= d_i;
  end

  assign q_o = q_r;

  // sampled on the falling global edge, away from rising-edge updates
  AST_D_LOAD: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (!tff_i && !negedge_i && !lclk_sel_i && !clr_i &&
     $past(!tff_i && !negedge_i && !lclk_sel_i && !clr_i && rst_ni))
    |-> (q_o == $past(d_i)));  // R4

  AST_T_TOGGLE: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (tff_i && !negedge_i && !lclk_sel_i && !clr_i &&
     $past(tff_i && !negedge_i && !lclk_sel_i && !clr_i && rst_ni))
    |-> (q_o == ($past(q_o) ^ $past(d_i))));  // R5

  AST_CLR_WINS: assert property (@(negedge clk_i) disable iff (!rst_ni)
    clr_i |-> !q_o);  // R8
endmodule

// File: rtl/pmc_pin.sv
`timescale 1ns/1ps
module pmc_pin
  import pmc_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic       pt_oe_i,
  input  logic       val_i,
  input  logic       fb_pin_i,
  input  logic       q_i,
  input  logic       pin_i,
  output logic       pin_o,
  output logic       pin_oe_o,
  output logic       fb_o
);
  pin_mode_e mode;
  logic      oe, ded_in, pin_level;

  assign mode = pin_mode_e'(mode_i);

  always_comb begin
    unique case (mode)
      PIN_BIDIR: oe = pt_oe_i;
      PIN_OUT:   oe = 1'b1;
      default:   oe = 1'b0;
    endcase
  end

  assign ded_in    = (mode == PIN_IN) || (mode == PIN_IN_ALT);
  assign pin_level = oe ? val_i : pin_i;
  assign pin_oe_o  = oe;
  assign pin_o     = oe & val_i;
  assign fb_o      = ded_in ? pin_i : (fb_pin_i ? pin_level : q_i);
endmodule

// File: rtl/pld_macrocell.sv
`timescale 1ns/1ps
module pld_macrocell #(
  parameter int N_PT = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_PT-1:0] pt_sum_i,
  input  logic            pt_oe_i,
  input  logic            pt_clk_i,
  input  logic            pt_clr_i,
  input  logic            cfg_pol_i,
  input  logic            cfg_xor_i,
  input  logic            cfg_reg_i,
  input  logic            cfg_tff_i,
  input  logic            cfg_negedge_i,
  input  logic            cfg_lclk_i,
  input  logic [1:0]      cfg_pin_mode_i,
  input  logic            cfg_fb_pin_i,
  input  logic            pin_i,
  output logic            pin_o,
  output logic            pin_oe_o,
  output logic            fb_o
);
  logic sum, q, out_val;

  pmc_sum #(.N_PT(N_PT)) u_sum (
    .pt_i     (pt_sum_i),
    .xor_en_i (cfg_xor_i),
    .sum_o    (sum)
  );

  pmc_ff u_ff (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lclk_i     (pt_clk_i),
    .lclk_sel_i (cfg_lclk_i),
    .negedge_i  (cfg_negedge_i),
    .tff_i      (cfg_tff_i),
    .clr_i      (pt_clr_i),
    .d_i        (sum),
    .q_o        (q)
  );

  // polarity after storage so toggle mode keeps its meaning
  assign out_val = (cfg_reg_i ? q : sum) ^ cfg_pol_i;

  pmc_pin u_pin (
    .mode_i   (cfg_pin_mode_i),
    .pt_oe_i  (pt_oe_i),
    .val_i    (out_val),
    .fb_pin_i (cfg_fb_pin_i),
    .q_i      (q),
    .pin_i    (pin_i),
    .pin_o    (pin_o),
    .pin_oe_o (pin_oe_o),
    .fb_o     (fb_o)
  );

  AST_COMB_OR: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (!cfg_reg_i && !cfg_xor_i && pin_oe_o) |-> (pin_o == ((|pt_sum_i) ^ cfg_pol_i)));  // R1

  AST_PIN_QUIET: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !pin_oe_o |-> !pin_o);  // R10

  AST_DED_OUT: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (cfg_pin_mode_i == 2'd1) |-> pin_oe_o);  // R9

  AST_DED_IN: assert property (@(negedge clk_i) disable iff (!rst_ni)
    cfg_pin_mode_i[1] |-> (!pin_oe_o && (fb_o == pin_i)));  // R12
endmodule

// File: tb/pld_macrocell_tb.sv
`timescale 1ns/1ps
module pld_macrocell_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_ni;
  logic [7:0] pt;
  logic       pt_oe, pt_clk, pt_clr;
  logic       pol, xr, rg, tff, neg, lclk, fbp, pin_in;
  logic [1:0] mode;
  logic       pin_o, pin_oe, fb;

  logic       cnt_clr;
  logic       c0_pin, c0_oe, c0_fb, c1_pin, c1_oe, c1_fb;
  logic [7:0] c1_pt;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  pld_macrocell u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .pt_sum_i(pt), .pt_oe_i(pt_oe), .pt_clk_i(pt_clk),
    .pt_clr_i(pt_clr), .cfg_pol_i(pol), .cfg_xor_i(xr), .cfg_reg_i(rg), .cfg_tff_i(tff),
    .cfg_negedge_i(neg), .cfg_lclk_i(lclk), .cfg_pin_mode_i(mode), .cfg_fb_pin_i(fbp),
    .pin_i(pin_in), .pin_o(pin_o), .pin_oe_o(pin_oe), .fb_o(fb)
  );

  assign c1_pt = {7'd0, c0_fb};

  pld_macrocell u_cnt0 (
    .clk_i(clk), .rst_ni(rst_ni), .pt_sum_i(8'h01), .pt_oe_i(1'b0), .pt_clk_i(1'b0),
    .pt_clr_i(cnt_clr), .cfg_pol_i(1'b0), .cfg_xor_i(1'b0), .cfg_reg_i(1'b1), .cfg_tff_i(1'b1),
    .cfg_negedge_i(1'b0), .cfg_lclk_i(1'b0), .cfg_pin_mode_i(2'd1), .cfg_fb_pin_i(1'b0),
    .pin_i(1'b0), .pin_o(c0_pin), .pin_oe_o(c0_oe), .fb_o(c0_fb)
  );

  pld_macrocell u_cnt1 (
    .clk_i(clk), .rst_ni(rst_ni), .pt_sum_i(c1_pt), .pt_oe_i(1'b0), .pt_clk_i(1'b0),
    .pt_clr_i(cnt_clr), .cfg_pol_i(1'b0), .cfg_xor_i(1'b0), .cfg_reg_i(1'b1), .cfg_tff_i(1'b1),
    .cfg_negedge_i(1'b0), .cfg_lclk_i(1'b0), .cfg_pin_mode_i(2'd1), .cfg_fb_pin_i(1'b0),
    .pin_i(1'b0), .pin_o(c1_pin), .pin_oe_o(c1_oe), .fb_o(c1_fb)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // reconfigure under clear, release one rising edge later (inputs move at edge+1)
  task automatic setup(input logic r, input logic t, input logic n, input logic l,
                       input logic p, input logic x, input logic [1:0] m, input logic f);
    tick();
    pt_clr = 1'b1;
    rg = r; tff = t; neg = n; lclk = l; pol = p; xr = x; mode = m; fbp = f;
    pt = 8'h00; pt_oe = 1'b0; pt_clk = 1'b0; pin_in = 1'b0;
    tick();
    pt_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R8 reset stored bit", fb, 1'b0);
    chk("R8 reset pin", pin_o, 1'b0);
  endtask

  task automatic t_comb_or();
    setup(0, 0, 0, 0, 0, 0, 2'd1, 0);
    #1 chk("R1 all terms low", pin_o, 1'b0);
    for (int k = 0; k < 8; k++) begin
      pt = 8'h01 << k;
      #1 chk($sformatf("R1 single term %0d", k), pin_o, 1'b1);
    end
    pt = 8'hFF;
    #1 chk("R1 all terms high", pin_o, 1'b1);
  endtask

  task automatic t_polarity();
    setup(0, 0, 0, 0, 1, 0, 2'd1, 0);
    #1 chk("R2 inverted empty sum", pin_o, 1'b1);
    pt = 8'h10;
    #1 chk("R2 inverted true sum", pin_o, 1'b0);
  endtask

  task automatic t_xor();
    setup(0, 0, 0, 0, 0, 1, 2'd1, 0);
    pt = 8'h01; #1 chk("R3 low group only", pin_o, 1'b1);
    pt = 8'h10; #1 chk("R3 high group only", pin_o, 1'b1);
    pt = 8'h11; #1 chk("R3 both groups", pin_o, 1'b0);
    pt = 8'h33; #1 chk("R3 both groups multi", pin_o, 1'b0);
    pt = 8'hF0; #1 chk("R3 high group full", pin_o, 1'b1);
    pt = 8'h00; #1 chk("R3 none", pin_o, 1'b0);
  endtask

  task automatic t_dff();
    setup(1, 0, 0, 0, 0, 0, 2'd1, 0);
    pt = 8'h04;
    #1 chk("R4 no load before edge", fb, 1'b0);
    tick();
    chk("R4 loaded one", fb, 1'b1);
    chk("R4 pin shows stored", pin_o, 1'b1);
    pol = 1'b1;
    #1 chk("R2 registered inverted", pin_o, 1'b0);
    pol = 1'b0;
    pt = 8'h00;
    tick();
    chk("R4 loaded zero", fb, 1'b0);
  endtask

  task automatic t_tff();
    setup(1, 1, 0, 0, 0, 0, 2'd1, 0);
    pt = 8'h80;
    tick(); chk("R5 toggle to one", fb, 1'b1);
    tick(); chk("R5 toggle to zero", fb, 1'b0);
    tick(); chk("R5 toggle to one again", fb, 1'b1);
    pt = 8'h00;
    tick(); chk("R5 hold one", fb, 1'b1);
    tick(); chk("R5 hold one second edge", fb, 1'b1);
  endtask

  task automatic t_negedge();
    setup(1, 0, 1, 0, 0, 0, 2'd1, 0);
    pt = 8'h01;
    #1 chk("R6 not yet loaded", fb, 1'b0);
    @(negedge clk); #1;
    chk("R6 loaded on falling edge", fb, 1'b1);
    pt = 8'h00;
    @(posedge clk); #1;
    chk("R6 rising edge ignored", fb, 1'b1);
    @(negedge clk); #1;
    chk("R6 cleared on falling edge", fb, 1'b0);
  endtask

  task automatic t_lclk();
    setup(1, 0, 0, 1, 0, 0, 2'd1, 0);
    pt = 8'h02;
    tick(); tick();
    chk("R7 global edges ignored", fb, 1'b0);
    pt_clk = 1'b1;
    #1 chk("R7 loaded on local clock", fb, 1'b1);
    tick();
    pt_clk = 1'b0;
    pt = 8'h00;
    tick();
    chk("R7 no load without local edge", fb, 1'b1);
    pt_clk = 1'b1;
    #1 chk("R7 second local edge", fb, 1'b0);
    tick();
    pt_clk = 1'b0;
  endtask

  task automatic t_clear();
    setup(1, 0, 0, 0, 0, 0, 2'd1, 0);
    pt = 8'h01;
    tick();
    chk("R8 preload", fb, 1'b1);
    pt_clr = 1'b1;
    #1 chk("R8 async clear", fb, 1'b0);
    tick();
    chk("R8 clear beats edge", fb, 1'b0);
    pt_clr = 1'b0;
    tick();
    chk("R8 reload after clear", fb, 1'b1);
    rst_ni = 1'b0;
    #1 chk("R8 async reset", fb, 1'b0);
    tick();
    rst_ni = 1'b1;
    tick();
    chk("R8 reload after reset", fb, 1'b1);
  endtask

  task automatic t_pin_modes();
    setup(0, 0, 0, 0, 0, 0, 2'd0, 0);
    pt = 8'h01;
    pt_oe = 1'b0;
    #1 chk("R9 bidir enable low", pin_oe, 1'b0);
    chk("R10 undriven pin low", pin_o, 1'b0);
    pt_oe = 1'b1;
    #1 chk("R9 bidir enable high", pin_oe, 1'b1);
    chk("R9 bidir drives sum", pin_o, 1'b1);
    mode = 2'd1; pt_oe = 1'b0;
    #1 chk("R9 dedicated output", pin_oe, 1'b1);
    mode = 2'd2; pt_oe = 1'b1;
    #1 chk("R9 dedicated input", pin_oe, 1'b0);
    chk("R10 dedicated input pin low", pin_o, 1'b0);
    mode = 2'd3;
    #1 chk("R9 mode 3 input", pin_oe, 1'b0);
    tick();
  endtask

  task automatic t_feedback();
    setup(1, 0, 0, 0, 0, 0, 2'd1, 0);
    pt = 8'h01;
    tick();
    pt = 8'h00;
    tff = 1'b1;  // hold the stored 1 with a zero sum
    mode = 2'd0; pt_oe = 1'b0; pin_in = 1'b0;
    #1 chk("R11 buried register feedback", fb, 1'b1);
    fbp = 1'b1;
    #1 chk("R11 pin feedback undriven low", fb, 1'b0);
    pin_in = 1'b1;
    #1 chk("R11 pin feedback undriven high", fb, 1'b1);
    pt_oe = 1'b1; pol = 1'b1;
    #1 chk("R11 pin feedback driven value", fb, 1'b0);
    pt_oe = 1'b0; pol = 1'b0; fbp = 1'b0;
    mode = 2'd2; pin_in = 1'b0;
    #1 chk("R12 input mode overrides register", fb, 1'b0);
    pin_in = 1'b1;
    #1 chk("R12 input mode follows pad", fb, 1'b1);
    mode = 2'd3; pin_in = 1'b0;
    #1 chk("R12 mode 3 follows pad", fb, 1'b0);
    tick();
  endtask

  task automatic t_counter();
    tick();
    cnt_clr = 1'b0;
    chk("R13 counter start low", c0_pin, 1'b0);
    chk("R13 counter start high", c1_pin, 1'b0);
    for (int k = 1; k <= 6; k++) begin
      tick();
      chk($sformatf("R13 count %0d bit0", k), c0_pin, 1'((k % 4) & 1));
      chk($sformatf("R13 count %0d bit1", k), c1_pin, 1'((k % 4) >> 1));
    end
  endtask

  initial begin
    rst_ni = 1'b0; cnt_clr = 1'b1;
    pt = 8'h00; pt_oe = 1'b0; pt_clk = 1'b0; pt_clr = 1'b0;
    pol = 1'b0; xr = 1'b0; rg = 1'b1; tff = 1'b0; neg = 1'b0; lclk = 1'b0;
    mode = 2'd1; fbp = 1'b0; pin_in = 1'b0;
    tick();
    pt = 8'h01;
    tick();
    t_reset();
    rst_ni = 1'b1;
    t_comb_or();
    t_polarity();
    t_xor();
    t_dff();
    t_tff();
    t_negedge();
    t_lclk();
    t_clear();
    t_pin_modes();
    t_feedback();
    t_counter();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule